// File: doc/BRIEF.md
# Latched Serial Control Register Port

This block receives 16-bit control words over a three-wire serial link (bit clock, data and a latch strobe) and keeps the decoded settings for a stereo audio datapath. Bits arrive MSB first and are taken on each rising edge of the control clock. When the latch strobe rises after exactly sixteen bits, the word is committed. A latch after any other number of bits throws the word away.

One bit of the word picks the left or right channel. The ten-bit volume request goes only to that channel. The global settings (input mode, soft power-down, de-emphasis and mute) are taken from every committed word, whichever channel it names. A committed volume first waits in a pending register. It reaches the datapath at the next edge of the frame clock, rising or falling, so that a volume step never lands in the middle of a sample pair.

All serial inputs and the frame clock pass through two-flop synchronisers into the system clock domain. Edges are then found in that domain. An active-low reset returns every setting to its default.

Top module: `ctlport_regs`

## Requirements
- R1: After reset both channel volumes read 0x3FF (no attenuation), mute and de-emphasis outputs are low, the input-mode output is 0 and the datapath-clear output is low.
- R2: Data is captured on control-clock rising edges, MSB first. A latch-strobe rising edge that follows exactly 16 captured bits commits the word.
- R3: A latch-strobe rising edge that follows a count other than 16 bits (for example 15 or 17) changes no setting. It also clears the bit count, so the next 16-bit word commits normally.
- R4: The word layout is: bits [15:14] input mode, bit 13 soft power-down, bit 12 de-emphasis, bit 11 mute (1 = muted), bit 10 channel select (1 = right, 0 = left), bits [9:0] volume.
- R5: Bits [15:11] are global. They take their new values from every committed word, whichever channel it selects, and appear at the outputs without waiting for a frame-clock edge.
- R6: The volume field is written only to the selected channel's pending register. The other channel keeps its value.
- R7: A channel's volume output changes only on a frame-clock edge, either polarity. At that edge it takes the pending value committed before the edge.
- R8: When a commit and a frame-clock edge fall in the same system-clock cycle, the volume outputs take the value pending before that commit. The new volume appears at the following frame-clock edge.
- R9: The mute output is the mute pin OR the mute bit. The de-emphasis output is the de-emphasis pin OR the de-emphasis bit.
- R10: The datapath-clear output follows the committed soft power-down bit. Reset clears that bit and returns both the pending and the active volumes of both channels to 0x3FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sclk | input | 1 | Serial control bit clock (asynchronous) |
| ctl_sdat | input | 1 | Serial control data, MSB first |
| ctl_latch | input | 1 | Latch strobe; a rising edge commits the word |
| frame_clk | input | 1 | Audio frame clock; both edges release pending volumes |
| mute_pin | input | 1 | Hardware mute request |
| deemph_pin | input | 1 | Hardware de-emphasis request |
| in_mode | output | 2 | Serial data input mode selected by the last committed word |
| dp_clear | output | 1 | Datapath clear, high while soft power-down is set |
| deemph_on | output | 1 | De-emphasis enable (pin OR bit) |
| mute_on | output | 1 | Mute enable (pin OR bit) |
| vol_left | output | 10 | Active left-channel volume |
| vol_right | output | 10 | Active right-channel volume |

## Verification
A commit and a frame-clock edge can land in the same system-clock cycle. This is the collision that matters: one path writes the pending register while the other copies it into the active register. The bench loads a word's sixteen bits and then raises the latch strobe and toggles the frame clock at the same instant. Both signals pass through synchronisers of equal depth, so their edges are detected in the same cycle. The bench then checks that the volume output keeps the old value, and that the new value appears only after the next frame-clock toggle.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int MODE_W = 2;
  localparam int VOL_W  = 10;
  localparam int WORD_W = MODE_W + 4 + VOL_W;
  localparam int NCH    = 2;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              pwr_dn;
    logic              deemph;
    logic              mute;
    logic              chan_r;
    logic [VOL_W-1:0]  vol;
  } ctl_word_t;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              pwr_dn;
    logic              deemph;
    logic              mute;
  } ctl_glob_t;

  localparam ctl_glob_t GLOB_RST = '0;

  function automatic logic [VOL_W-1:0] vol_default();
    return '1;
  endfunction

  function automatic ctl_glob_t glob_of(ctl_word_t w);
    ctl_glob_t g;
    g.mode   = w.mode;
    g.pwr_dn = w.pwr_dn;
    g.deemph = w.deemph;
    g.mute   = w.mute;
    return g;
  endfunction

  function automatic logic targets(ctl_word_t w, int ch);
    return (ch == 1) ? w.chan_r : !w.chan_r;
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              latch_stb,
  output logic              commit_stb,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W + 1) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      word_q  <= '0;
    end else if (latch_stb) begin
      bit_cnt <= '0;
    end else if (bit_stb) begin
      word_q <= {word_q[WORD_W-2:0], bit_val};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit_stb = latch_stb && (bit_cnt == FULL);
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_stb,
  input  ctl_word_t                 word,
  input  logic                      frame_stb,
  output ctl_glob_t                 glob_q,
  output logic [NCH-1:0][VOL_W-1:0] pend_v,
  output logic [NCH-1:0][VOL_W-1:0] act_v
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_q <= GLOB_RST;
    else if (commit_stb) glob_q <= glob_of(word);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [VOL_W-1:0] pend_q, act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= vol_default();
        act_q  <= vol_default();
      end else begin
        if (commit_stb && targets(word, ch)) pend_q <= word.vol;
        if (frame_stb) act_q <= pend_q;
      end
    end
    assign pend_v[ch] = pend_q;
    assign act_v[ch]  = act_q;
  end
endmodule

// File: rtl/ctlport_regs.sv
module ctlport_regs
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_sclk,
  input  logic              ctl_sdat,
  input  logic              ctl_latch,
  input  logic              frame_clk,
  input  logic              mute_pin,
  input  logic              deemph_pin,
  output logic [MODE_W-1:0] in_mode,
  output logic              dp_clear,
  output logic              deemph_on,
  output logic              mute_on,
  output logic [VOL_W-1:0]  vol_left,
  output logic [VOL_W-1:0]  vol_right
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, synced;
  logic sclk_s, sdat_s, latch_s, frame_s;
  logic sclk_p, latch_p, frame_p;

  assign raw_in = {ctl_sclk, ctl_sdat, ctl_latch, frame_clk};

  ctl_sync #(.STAGES(SYNC_STAGES), .W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );
  assign {sclk_s, sdat_s, latch_s, frame_s} = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= 1'b0;
      latch_p <= 1'b0;
      frame_p <= 1'b0;
    end else begin
      sclk_p  <= sclk_s;
      latch_p <= latch_s;
      frame_p <= frame_s;
    end
  end

  // named internal events, visible to the checker
  logic bit_stb, latch_stb, frame_stb, commit_stb;
  assign bit_stb   = sclk_s & ~sclk_p;
  assign latch_stb = latch_s & ~latch_p;
  assign frame_stb = frame_s ^ frame_p;

  logic [WORD_W-1:0] word_raw;
  ctl_word_t word;

  ctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(sdat_s),
    .latch_stb(latch_stb), .commit_stb(commit_stb), .word_q(word_raw)
  );
  assign word = ctl_word_t'(word_raw);

  ctl_glob_t glob_q;
  logic [NCH-1:0][VOL_W-1:0] pend_v, act_v;

  ctl_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit_stb(commit_stb), .word(word),
    .frame_stb(frame_stb), .glob_q(glob_q), .pend_v(pend_v), .act_v(act_v)
  );

  logic [VOL_W-1:0] pend_l, pend_r;
  assign pend_l = pend_v[0];
  assign pend_r = pend_v[1];

  assign in_mode   = glob_q.mode;
  assign dp_clear  = glob_q.pwr_dn;
  assign deemph_on = deemph_pin | glob_q.deemph;
  assign mute_on   = mute_pin | glob_q.mute;
  assign vol_left  = act_v[0];
  assign vol_right = act_v[1];
endmodule

// File: rtl/ctlport_chk.sv
module ctlport_chk #(
  parameter int VOL_W = 10,
  parameter int GW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit_stb,
  input logic             frame_stb,
  input logic             latch_stb,
  input logic             word_chan,
  input logic             word_mute,
  input logic             glob_mute,
  input logic [GW-1:0]    glob_all,
  input logic [VOL_W-1:0] pend_l,
  input logic [VOL_W-1:0] pend_r,
  input logic [VOL_W-1:0] vol_left,
  input logic [VOL_W-1:0] vol_right,
  input logic             mute_pin,
  input logic             mute_on
);
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vol_left == '1 && vol_right == '1 && pend_l == '1 && pend_r == '1));

  p_discard_bad_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && !commit_stb) |=> ($stable(glob_all) && $stable(pend_l) && $stable(pend_r)));

  p_global_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> (glob_mute == $past(word_mute)));

  p_left_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_stb && !word_chan) |=> $stable(pend_r));

  p_right_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_stb && word_chan) |=> $stable(pend_l));

  p_vol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(vol_left) && $stable(vol_right)));

  p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_stb && frame_stb) |=> (vol_left == $past(pend_l) && vol_right == $past(pend_r)));

  p_mute_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mute_pin |-> mute_on);
endmodule

bind ctlport_regs ctlport_chk #(.VOL_W(ctl_pkg::VOL_W), .GW(5)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_stb(commit_stb), .frame_stb(frame_stb),
  .latch_stb(latch_stb), .word_chan(word.chan_r), .word_mute(word.mute),
  .glob_mute(glob_q.mute), .glob_all(glob_q), .pend_l(pend_l), .pend_r(pend_r),
  .vol_left(vol_left), .vol_right(vol_right), .mute_pin(mute_pin), .mute_on(mute_on)
);

// File: tb/ctlport_regs_test.sv
`timescale 1ns/1ps
module ctlport_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_sclk = 1'b0, ctl_sdat = 1'b0, ctl_latch = 1'b0, frame_clk = 1'b0;
  logic mute_pin = 1'b0, deemph_pin = 1'b0;
  logic [1:0] in_mode;
  logic dp_clear, deemph_on, mute_on;
  logic [9:0] vol_left, vol_right;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctlport_regs uut (
    .clk(clk), .rst_n(rst_n), .ctl_sclk(ctl_sclk), .ctl_sdat(ctl_sdat),
    .ctl_latch(ctl_latch), .frame_clk(frame_clk), .mute_pin(mute_pin),
    .deemph_pin(deemph_pin), .in_mode(in_mode), .dp_clear(dp_clear),
    .deemph_on(deemph_on), .mute_on(mute_on), .vol_left(vol_left), .vol_right(vol_right)
  );

  // word layout: [15:14] mode, 13 power-down, 12 de-emphasis, 11 mute, 10 right, [9:0] volume
  function automatic logic [15:0] mk(logic [1:0] m, logic pd, logic de, logic mu, logic rch, logic [9:0] v);
    return {m, pd, de, mu, rch, v};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(int n = 10);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) ctl_sdat = v[i];
      settle(4);
      ctl_sclk = 1'b1;
      settle(4);
      ctl_sclk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    settle(4);
    ctl_latch = 1'b1;
    settle(6);
    ctl_latch = 1'b0;
    settle(6);
  endtask

  task automatic toggle_frame();
    @(negedge clk) frame_clk = ~frame_clk;
    settle();
  endtask

  task automatic t_reset();
    check("R1 vol_left", vol_left, 10'h3FF);
    check("R1 vol_right", vol_right, 10'h3FF);
    check("R1 mute_on", mute_on, 0);
    check("R1 deemph_on", deemph_on, 0);
    check("R1 in_mode", in_mode, 0);
    check("R1 dp_clear", dp_clear, 0);
  endtask

  task automatic t_left_write();
    send_bits(mk(2'b10, 0, 1, 0, 0, 10'h155), 16);
    pulse_latch();
    check("R4 in_mode field", in_mode, 2);
    check("R4 deemph field", deemph_on, 1);
    check("R7 left held before frame edge", vol_left, 10'h3FF);
    toggle_frame();
    check("R7 left after rising frame edge", vol_left, 10'h155);
    check("R6 right untouched", vol_right, 10'h3FF);
  endtask

  task automatic t_right_write();
    send_bits(mk(2'b01, 0, 0, 1, 1, 10'h0AA), 16);
    pulse_latch();
    check("R5 mute from right word", mute_on, 1);
    check("R5 deemph cleared by right word", deemph_on, 0);
    check("R5 in_mode from right word", in_mode, 1);
    check("R7 right held before frame edge", vol_right, 10'h3FF);
    toggle_frame();
    check("R7 right after falling frame edge", vol_right, 10'h0AA);
    check("R6 left untouched", vol_left, 10'h155);
  endtask

  task automatic t_bad_count();
    send_bits(mk(2'b11, 0, 1, 0, 0, 10'h001), 15);
    pulse_latch();
    check("R3 15 bits mode kept", in_mode, 1);
    check("R3 15 bits deemph kept", deemph_on, 0);
    toggle_frame();
    check("R3 15 bits left vol kept", vol_left, 10'h155);
    send_bits({15'h0, 1'b1, mk(2'b11, 0, 1, 0, 0, 10'h002)}, 17);
    pulse_latch();
    check("R3 17 bits mode kept", in_mode, 1);
    check("R3 17 bits mute kept", mute_on, 1);
    toggle_frame();
    check("R3 17 bits left vol kept", vol_left, 10'h155);
    send_bits(mk(2'b00, 0, 0, 0, 1, 10'h123), 16);
    pulse_latch();
    check("R2 commit after discard mute", mute_on, 0);
    toggle_frame();
    check("R2 commit after discard right vol", vol_right, 10'h123);
  endtask

  task automatic t_same_cycle();
    send_bits(mk(2'b00, 0, 0, 0, 0, 10'h2C3), 16);
    settle(4);
    ctl_latch = 1'b1;
    frame_clk = ~frame_clk;
    settle();
    ctl_latch = 1'b0;
    settle(6);
    check("R8 same-cycle edge keeps old left", vol_left, 10'h155);
    toggle_frame();
    check("R8 following edge applies new left", vol_left, 10'h2C3);
    check("R8 right unchanged", vol_right, 10'h123);
  endtask

  task automatic t_pins();
    check("R9 mute off with pin low", mute_on, 0);
    @(negedge clk) mute_pin = 1'b1;
    settle(2);
    check("R9 mute pin", mute_on, 1);
    deemph_pin = 1'b1;
    settle(2);
    check("R9 deemph pin", deemph_on, 1);
    mute_pin = 1'b0;
    deemph_pin = 1'b0;
    settle(2);
    check("R9 mute released", mute_on, 0);
    check("R9 deemph released", deemph_on, 0);
  endtask

  task automatic t_power_down();
    send_bits(mk(2'b00, 1, 0, 0, 0, 10'h000), 16);
    pulse_latch();
    check("R10 soft power-down raises clear", dp_clear, 1);
    @(negedge clk) rst_n = 1'b0;
    settle(4);
    rst_n = 1'b1;
    settle(4);
    check("R10 reset clears power-down", dp_clear, 0);
    check("R10 reset left vol", vol_left, 10'h3FF);
    check("R10 reset right vol", vol_right, 10'h3FF);
    toggle_frame();
    check("R10 pending left reset", vol_left, 10'h3FF);
    check("R10 pending right reset", vol_right, 10'h3FF);
  endtask

  initial begin
    settle(5);
    rst_n = 1'b1;
    settle(4);
    t_reset();
    t_left_write();
    t_right_write();
    t_bad_count();
    t_same_cycle();
    t_pins();
    t_power_down();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule